// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. The global one hashes the branch address with a shift register of recent outcomes and indexes a table of 3-bit counters. The local one first reads a per-branch outcome history, selected by low address bits. It then combines that history with the address by XOR and indexes a table of 2-bit counters. A third table of 2-bit counters, indexed by address alone, decides which of the two answers to give for each branch.

The pipeline issues a lookup with a branch address and receives the direction one cycle later, together with both component answers and the choice made. When the branch resolves, the pipeline presents its address and real outcome on the update port. Both components are trained on every update. The chooser learns only when the components disagree. The global history and the branch's local history entry both shift the outcome in.

Index widths are parameters. The full-size configuration uses a 4096-entry chooser, 14 history bits for 16384 global counters, a 256-entry history table, and 12-bit local histories. The defaults are scaled down so the block stays small for elaboration.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every global counter holds 3 (binary 011), every local and chooser counter holds 1 (binary 01), and the global history and all local histories are zero. The first prediction is therefore not-taken from both components, with the global component chosen.
- R2: A lookup sampled on a rising edge with `lk_valid` high sets `pred_valid` high after that edge. `pred_valid` is low after any edge where `lk_valid` was low.
- R3: The global answer is the most significant bit of the global counter at index `pc[2 +: GHIST_W] XOR ghist`, where `ghist` is the global history.
- R4: The local answer is found in two steps. First, read the history at entry `pc[2 +: L1_IDX_W]`. Then take the most significant bit of the local counter at `pc[2 +: LHIST_W] XOR` that history.
- R5: The chooser counter is at `pc[2 +: SEL_IDX_W]`. If its most significant bit is set, `pred_use_local` is 1 and `pred_taken` equals the local answer. Otherwise `pred_taken` equals the global answer.
- R6: Counters saturate. A 3-bit counter stays in the range 0 to 7, and a 2-bit counter stays in the range 0 to 3.
- R7: Every update moves the addressed global counter and the addressed local counter toward the outcome, whichever component was chosen. The indices are formed as in R3 and R4 from the histories held before the update.
- R8: The chooser counter moves up when only the local answer was correct and down when only the global answer was correct. It is left unchanged when the two answers agree.
- R9: An update shifts the global history left and puts the outcome in bit 0. Without an update the global history holds.
- R10: An update shifts the outcome into bit 0 of the local history entry addressed by `upd_pc`.
- R11: A lookup and an update on the same edge: the lookup sees the tables and histories as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Branch address to predict |
| upd_valid | input | 1 | Resolved-branch update |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| pred_valid | output | 1 | Prediction outputs are valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_glob | output | 1 | Global component answer |
| pred_loc | output | 1 | Local component answer |
| pred_use_local | output | 1 | Chooser picked the local component |

## Verification
The prediction outputs of a lookup are due one rising edge after the lookup is sampled. The effects of an update are seen by any lookup sampled on a later edge. A lookup on the same edge as an update still sees the older state. The bench drives every input at a falling edge. It then waits one rising edge and samples at the following falling edge. Expected values come from a table model kept in the bench, which is read before it applies that cycle's update, so the comparison lands on the exact cycle each result is due.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Low address bits dropped before indexing (word-aligned branches).
  localparam int PC_LSB = 2;

  typedef enum logic {
    PICK_GLOBAL = 1'b0,
    PICK_LOCAL  = 1'b1
  } pick_e;
endpackage

// File: rtl/tp_sat_table.sv
// Table of saturating counters: two read ports, one read-modify-write port.
module tp_sat_table #(
  parameter int              IDX_W   = 8,
  parameter int              CTR_W   = 2,
  parameter logic [CTR_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CTR_W-1:0] rd_a_ctr,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CTR_W-1:0] rd_b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int               DEPTH   = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic [CTR_W-1:0] mem_q [DEPTH];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;

  assign rd_a_ctr = mem_q[rd_a_idx];
  assign rd_b_ctr = mem_q[rd_b_idx];
  assign wr_cur   = mem_q[wr_idx];

  always_comb begin
    wr_nxt = wr_cur;
    if (wr_up) begin
      if (wr_cur != CTR_MAX) wr_nxt = wr_cur + 1'b1;
    end else begin
      if (wr_cur != CTR_MIN) wr_nxt = wr_cur - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= RST_VAL;
      else if (ent_en) mem_q[g] <= wr_nxt;
    end
  end

  // R6: a counter at its top that is pushed up stays at its top
  assert_sat_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_cur == CTR_MAX) |=> (mem_q[$past(wr_idx)] == CTR_MAX));
  // R6: a counter at zero that is pushed down stays at zero
  assert_sat_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_cur == CTR_MIN) |=> (mem_q[$past(wr_idx)] == CTR_MIN));
  // R8: without a write the entry seen on port A keeps its value
  assert_hold_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem_q[$past(rd_a_idx)] == $past(rd_a_ctr)));
endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome history table: two read ports, one shift-in write port.
module tp_hist_table #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [HIST_W-1:0] rd_a_hist,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [HIST_W-1:0] rd_b_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem_q [DEPTH];
  logic [HIST_W-1:0] wr_nxt;

  assign rd_a_hist = mem_q[rd_a_idx];
  assign rd_b_hist = mem_q[rd_b_idx];

  always_comb begin
    wr_nxt = {mem_q[wr_idx][HIST_W-2:0], wr_bit};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[g] <= '0;
      else if (ent_en) mem_q[g] <= wr_nxt;
    end
  end

  // R10: the newest outcome lands in bit 0 of the written entry
  assert_local_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_idx)][0] == $past(wr_bit)));
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int GHIST_W   = 8,
  parameter int GCTR_W    = 3,
  parameter int L1_IDX_W  = 6,
  parameter int LHIST_W   = 8,
  parameter int LCTR_W    = 2,
  parameter int SEL_IDX_W = 8,
  parameter int SCTR_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_glob,
  output logic            pred_loc,
  output logic            pred_use_local
);
  // Weak-not-taken resets: MSB clear, all lower bits set.
  localparam logic [GCTR_W-1:0] GLOB_RST = {1'b0, {(GCTR_W-1){1'b1}}};
  localparam logic [LCTR_W-1:0] LOC_RST  = {1'b0, {(LCTR_W-1){1'b1}}};
  localparam logic [SCTR_W-1:0] SEL_RST  = {1'b0, {(SCTR_W-1){1'b1}}};

  // Global history register
  logic [GHIST_W-1:0] ghist_q, ghist_d;

  always_comb begin
    ghist_d = ghist_q;
    if (upd_valid) ghist_d = {ghist_q[GHIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ghist_q <= '0;
    else if (upd_valid) ghist_q <= ghist_d;
  end

  // Index formation, lookup side and update side
  logic [GHIST_W-1:0]   gidx_lk, gidx_up;
  logic [L1_IDX_W-1:0]  hidx_lk, hidx_up;
  logic [LHIST_W-1:0]   lhist_lk, lhist_up;
  logic [LHIST_W-1:0]   lidx_lk, lidx_up;
  logic [SEL_IDX_W-1:0] sidx_lk, sidx_up;

  assign gidx_lk = lk_pc[PC_LSB +: GHIST_W]  ^ ghist_q;
  assign gidx_up = upd_pc[PC_LSB +: GHIST_W] ^ ghist_q;
  assign hidx_lk = lk_pc[PC_LSB +: L1_IDX_W];
  assign hidx_up = upd_pc[PC_LSB +: L1_IDX_W];
  assign lidx_lk = lk_pc[PC_LSB +: LHIST_W]  ^ lhist_lk;
  assign lidx_up = upd_pc[PC_LSB +: LHIST_W] ^ lhist_up;
  assign sidx_lk = lk_pc[PC_LSB +: SEL_IDX_W];
  assign sidx_up = upd_pc[PC_LSB +: SEL_IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc, upd_pc};

  // Local first level
  tp_hist_table #(.IDX_W(L1_IDX_W), .HIST_W(LHIST_W)) i_lhist (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(hidx_lk), .rd_a_hist(lhist_lk),
    .rd_b_idx(hidx_up), .rd_b_hist(lhist_up),
    .wr_en(upd_valid), .wr_idx(hidx_up), .wr_bit(upd_taken)
  );

  // Global counters
  logic [GCTR_W-1:0] gctr_lk, gctr_up;
  tp_sat_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(GLOB_RST)) i_gtab (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(gidx_lk), .rd_a_ctr(gctr_lk),
    .rd_b_idx(gidx_up), .rd_b_ctr(gctr_up),
    .wr_en(upd_valid), .wr_idx(gidx_up), .wr_up(upd_taken)
  );

  // Local second-level counters
  logic [LCTR_W-1:0] lctr_lk, lctr_up;
  tp_sat_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(LOC_RST)) i_ltab (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lidx_lk), .rd_a_ctr(lctr_lk),
    .rd_b_idx(lidx_up), .rd_b_ctr(lctr_up),
    .wr_en(upd_valid), .wr_idx(lidx_up), .wr_up(upd_taken)
  );

  // Chooser: trained only when the components disagree at update time
  logic              g_up_taken, l_up_taken;
  logic              sel_wr_en, sel_wr_up;
  logic [SCTR_W-1:0] sctr_lk, sctr_up;

  assign g_up_taken = gctr_up[GCTR_W-1];
  assign l_up_taken = lctr_up[LCTR_W-1];
  assign sel_wr_en  = upd_valid && (g_up_taken != l_up_taken);
  assign sel_wr_up  = (l_up_taken == upd_taken);

  tp_sat_table #(.IDX_W(SEL_IDX_W), .CTR_W(SCTR_W), .RST_VAL(SEL_RST)) i_stab (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(sidx_lk), .rd_a_ctr(sctr_lk),
    .rd_b_idx(sidx_up), .rd_b_ctr(sctr_up),
    .wr_en(sel_wr_en), .wr_idx(sidx_up), .wr_up(sel_wr_up)
  );

  logic unused_sel_rd;
  assign unused_sel_rd = ^sctr_up;

  // Prediction register stage
  pick_e pick_d;
  logic  glob_d, loc_d, taken_d;
  logic  valid_q, glob_q, loc_q, taken_q;
  pick_e pick_q;

  always_comb begin
    glob_d  = gctr_lk[GCTR_W-1];
    loc_d   = lctr_lk[LCTR_W-1];
    pick_d  = sctr_lk[SCTR_W-1] ? PICK_LOCAL : PICK_GLOBAL;
    taken_d = (pick_d == PICK_LOCAL) ? loc_d : glob_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q  <= 1'b0;
      loc_q   <= 1'b0;
      taken_q <= 1'b0;
      pick_q  <= PICK_GLOBAL;
    end else if (lk_valid) begin
      glob_q  <= glob_d;
      loc_q   <= loc_d;
      taken_q <= taken_d;
      pick_q  <= pick_d;
    end
  end

  assign pred_valid     = valid_q;
  assign pred_glob      = glob_q;
  assign pred_loc       = loc_q;
  assign pred_taken     = taken_q;
  assign pred_use_local = (pick_q == PICK_LOCAL);

  // R9: newest outcome enters bit 0 of the global history
  assert_ghist_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist_q[0] == $past(upd_taken)));
  // R9: the global history holds when no update arrives
  assert_ghist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist_q));
  // R2: no lookup, no valid prediction on the next cycle
  assert_no_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);
  // R5: the final answer always matches the component that was picked
  assert_pick_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (pred_taken == (pred_use_local ? pred_loc : pred_glob)));
endmodule

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;
  localparam int G  = 8;
  localparam int L1 = 6;
  localparam int LH = 8;
  localparam int S  = 8;
  localparam int GMAX = 7;
  localparam int LMAX = 3;
  localparam int SMAX = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred_valid, pred_taken, pred_glob, pred_loc, pred_use_local;

  always #2.5 clk = ~clk;

  tournament_predictor i_tournament_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_glob(pred_glob), .pred_loc(pred_loc), .pred_use_local(pred_use_local)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference tables, built from the requirements
  int gm [1<<G];
  int lm [1<<LH];
  int sm [1<<S];
  int hm [1<<L1];
  int gh;

  function automatic int sat(int v, int mx, bit up);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  function automatic int fld(logic [31:0] pc, int w);
    return int'((pc >> 2) & ((32'd1 << w) - 1));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1<<G); i++)  gm[i] = 3;
    for (int i = 0; i < (1<<LH); i++) lm[i] = 1;
    for (int i = 0; i < (1<<S); i++)  sm[i] = 1;
    for (int i = 0; i < (1<<L1); i++) hm[i] = 0;
    gh = 0;
  endtask

  task automatic check(input string what, input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, sample at the falling edge after the next rise.
  task automatic step(input bit lv, input logic [31:0] lp, input bit uv,
                      input logic [31:0] up, input bit ut, input string req);
    int eg, el, eu, et;
    lk_valid = lv; lk_pc = lp; upd_valid = uv; upd_pc = up; upd_taken = ut;
    eg = gm[fld(lp, G) ^ gh] >= 4;
    el = lm[fld(lp, LH) ^ hm[fld(lp, L1)]] >= 2;
    eu = sm[fld(lp, S)] >= 2;
    et = eu ? el : eg;
    if (uv) begin
      int gi, li, hi, si, gp, lpd;
      gi = fld(up, G) ^ gh;
      hi = fld(up, L1);
      li = fld(up, LH) ^ hm[hi];
      si = fld(up, S);
      gp = gm[gi] >= 4;
      lpd = lm[li] >= 2;
      gm[gi] = sat(gm[gi], GMAX, ut);
      lm[li] = sat(lm[li], LMAX, ut);
      if (gp != lpd) sm[si] = sat(sm[si], SMAX, lpd == int'(ut));
      gh = ((gh << 1) | int'(ut)) & ((1 << G) - 1);
      hm[hi] = ((hm[hi] << 1) | int'(ut)) & ((1 << LH) - 1);
    end
    @(posedge clk); @(negedge clk);
    check("pred_valid", "R2", int'(pred_valid), int'(lv));
    if (lv) begin
      check("pred_glob", req, int'(pred_glob), eg);
      check("pred_loc", req, int'(pred_loc), el);
      check("pred_use_local", req, int'(pred_use_local), eu);
      check("pred_taken", req, int'(pred_taken), et);
    end
  endtask

  task automatic t_reset();   // R1
    check("pred_valid after reset", "R1", int'(pred_valid), 0);
    step(1, 32'h0000_0100, 0, '0, 0, "R1");
    check("first prediction not-taken", "R1", int'(pred_taken), 0);
    check("first pick global", "R1", int'(pred_use_local), 0);
    step(1, 32'h0000_3a7c, 0, '0, 0, "R1");
  endtask

  task automatic t_idle();    // R2
    step(0, 32'h40, 0, '0, 0, "R2");
    step(0, 32'h40, 1, 32'h40, 1, "R2");
  endtask

  task automatic t_global_train();   // R3 R7 R9
    for (int i = 0; i < 20; i++) step(1, 32'h0000_0204, 1, 32'h0000_0204, 1, "R3_R7_R9");
    step(1, 32'h0000_0204, 0, '0, 0, "R3");
    check("global learned taken", "R7", int'(pred_glob), 1);
  endtask

  task automatic t_saturate();   // R6
    for (int i = 0; i < 12; i++) step(0, '0, 1, 32'h0000_0808, 1, "R6");
    step(1, 32'h0000_0808, 1, 32'h0000_0808, 0, "R6");
    step(1, 32'h0000_0808, 0, '0, 0, "R6");
    for (int i = 0; i < 12; i++) step(0, '0, 1, 32'h0000_0808, 0, "R6");
    step(1, 32'h0000_0808, 1, 32'h0000_0808, 1, "R6");
  endtask

  task automatic t_local_pattern();   // R4 R5 R8 R10
    for (int i = 0; i < 60; i++) begin
      step(1, 32'h0000_1110, 0, '0, 0, "R4_R5");
      step(0, '0, 1, 32'h0000_1110, i[0], "R10");
      step(0, '0, 1, 32'h0000_5550, 1'b1, "R8");
    end
    step(1, 32'h0000_1110, 0, '0, 0, "R8");
  endtask

  task automatic t_same_cycle();   // R11
    step(1, 32'h0000_2224, 1, 32'h0000_2224, 1, "R11");
    step(1, 32'h0000_2224, 1, 32'h0000_2224, 1, "R11");
    step(1, 32'h0000_2224, 1, 32'h0000_2224, 0, "R11");
  endtask

  task automatic t_mix();   // R3 R4 R5 R7 R8
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = {24'd0, 8'($urandom_range(0, 15))} << 2;
      b = {24'd0, 8'($urandom_range(0, 15))} << 2;
      step(1, a, 1, b, 1'($urandom_range(0, 1)), "R3_R4_R5_R7_R8");
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_global_train();
    t_saturate();
    t_local_pattern();
    t_same_cycle();
    t_mix();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule